// File: doc/BRIEF.md
# Bus Performance Counter Unit

This block is a performance monitor programmed over APB. It has four event counters and one cycle counter. Each event counter counts pulses on one bit of the event input vector. A per-counter event code selects which bit. The cycle counter counts clock cycles. Counting is controlled at two levels: a global enable and a separate enable bit for each counter.

Software handles enables, interrupt enables and reset requests through 32-bit masks. In every mask, bit positions 0 to 3 select event counters 0 to 3 and bit position 31 selects the cycle counter. When a counter wraps it raises a sticky overflow flag. A single interrupt line reports any flag whose interrupt enable is set. Counters 2 and 3 are wider than the others, so software reads each of them as a low word and a high word.

Top module: `perfmon_apb`

## Requirements
- R1: The version word at 0x000 reads 0x00045000, with field 19:12 equal to 0x45. An undefined address reads zero. `pready` is always high, so every access finishes in its second cycle.
- R2: The control register is at 0x004.
  - Bit 0 is the global count enable.
  - Bits 21:20 hold the operating mode and read back as written. Mode 0 is manual.
  - Writing 1 to bit 1 zeroes all four event counters. Writing 1 to bit 2 zeroes the cycle counter.
  - Bits 1 and 2 act as one-cycle pulses and always read as zero.
- R3: Counter enable has a set address (0x008) and a clear address (0x00C). Interrupt enable has a set address (0x010) and a clear address (0x014). Writing ones sets or clears the matching mask bits. Reading either address of a pair returns the current mask. In the mask, bits 0 to 3 are the event counters and bit 31 is the cycle counter.
- R4: A counter adds one in a clock cycle only when all of these are true:
  - the global enable is set;
  - its own enable bit is set;
  - its event is present.
  For event counter i, the event is `ev_in[code]`. The code is bits 7:0 of the register at 0x200 + 4·i. A code of `NUM_EVENTS` or more never counts. The cycle counter's event is present in every cycle.
- R5: Counters 0 and 1 and the cycle counter are `SHORT_W` bits wide (default 32). Counters 2 and 3 are `LONG_W` bits wide (default 40).
  - Counter 0 reads at 0x034 and counter 1 at 0x038.
  - Counter 2 reads its low `SHORT_W` bits at 0x03C and its upper bits at 0x054, placed from bit 0 up.
  - Counter 3 reads its low bits at 0x040 and its upper bits at 0x044, placed the same way.
  - The cycle counter reads at 0x048.
- R6: When a counter steps from all ones to zero, its flag bit in 0x018 is set. Writing ones to 0x018 clears the matching flags. Writing 0x8000000F clears all of them. If a wrap and a clear hit the same flag in the same cycle, the wrap wins.
- R7: `irq` is high exactly when some flag bit and its matching interrupt enable bit are both set.
- R8: Writing a mask to 0x02C zeroes each selected counter. A reset from this register or from the control register overrides an increment in the same cycle. The address 0x02C reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during a read access |
| pready | output | 1 | APB ready, tied high |
| ev_in | input | NUM_EVENTS | Event pulse inputs, one count per cycle while high |
| irq | output | 1 | Overflow interrupt |

## Verification
The event inputs are driven in three patterns.
- All low: a counter must not move when nothing happens.
- All high: every enabled counter gains exactly one per cycle. This separates the enable gating from the event selection.
- A fresh random vector every cycle: this exposes a wrong code-to-input mapping, which steady patterns would hide.

Small counter widths make both the short and the long counters wrap within the run. This exercises the flags, the interrupt and the split high word. Counter resets are issued while events are still arriving, so the reset-over-increment priority is observed at the ports.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  // Slots 0..3 are event counters; slot 4 is the cycle counter.
  localparam int NUM_SLOTS = 5;
  localparam int NUM_EVCNT = 4;
  localparam int CYC_SLOT  = 4;

  localparam logic [11:0] A_VERSION = 12'h000;
  localparam logic [11:0] A_CTRL    = 12'h004;
  localparam logic [11:0] A_CEN_SET = 12'h008;
  localparam logic [11:0] A_CEN_CLR = 12'h00C;
  localparam logic [11:0] A_IEN_SET = 12'h010;
  localparam logic [11:0] A_IEN_CLR = 12'h014;
  localparam logic [11:0] A_FLAGS   = 12'h018;
  localparam logic [11:0] A_CRST    = 12'h02C;
  localparam logic [11:0] A_CNT0    = 12'h034;
  localparam logic [11:0] A_CNT1    = 12'h038;
  localparam logic [11:0] A_CNT2_LO = 12'h03C;
  localparam logic [11:0] A_CNT3_LO = 12'h040;
  localparam logic [11:0] A_CNT3_HI = 12'h044;
  localparam logic [11:0] A_CYC     = 12'h048;
  localparam logic [11:0] A_CNT2_HI = 12'h054;
  localparam logic [7:0]  EVSEL_PAGE = 8'h20;  // 0x200..0x20C

  localparam logic [7:0] VERSION_ID = 8'h45;

  // Bus mask (bits 3:0 and 31) to slot vector.
  function automatic logic [NUM_SLOTS-1:0] mask_to_slots(input logic [31:0] m);
    return {m[31], m[3:0]};
  endfunction

  // Slot vector back to the bus mask layout.
  function automatic logic [31:0] slots_to_mask(input logic [NUM_SLOTS-1:0] s);
    return {s[CYC_SLOT], 27'd0, s[3:0]};
  endfunction

  function automatic logic [31:0] version_word();
    return {12'd0, VERSION_ID, 12'd0};
  endfunction
endpackage

// File: rtl/perfmon_evsel.sv
module perfmon_evsel #(
  parameter int NUM_EVENTS = 16
) (
  input  logic [NUM_EVENTS-1:0] ev_in,
  input  logic [7:0]            code,
  output logic                  hit
);
  // A code past the last input matches nothing.
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVENTS; k++) begin
      if (code == 8'(k)) hit = ev_in[k];
    end
  end
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         wrap
);
  // Clear has priority over increment; a cleared cycle never wraps.
  assign wrap = inc & ~clr & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (clr)    value <= '0;
    else if (inc)    value <= value + W'(1);
  end
endmodule

// File: rtl/perfmon_apb.sv
module perfmon_apb
  import perfmon_pkg::*;
#(
  parameter int SHORT_W    = 32,
  parameter int LONG_W     = 40,
  parameter int NUM_EVENTS = 16
) (
  input  logic                  pclk,
  input  logic                  presetn,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [11:0]           paddr,
  input  logic [31:0]           pwdata,
  output logic [31:0]           prdata,
  output logic                  pready,
  input  logic [NUM_EVENTS-1:0] ev_in,
  output logic                  irq
);
  localparam int HI_W = LONG_W - SHORT_W;

  // Programmed state
  logic                 glb_en;
  logic [1:0]           mode;
  logic [NUM_SLOTS-1:0] cnt_en;
  logic [NUM_SLOTS-1:0] int_en;
  logic [NUM_SLOTS-1:0] flags;
  logic [7:0]           ev_code [NUM_EVCNT];

  // Named internal events
  logic                 wr_en;
  logic                 evsel_wr;
  logic [NUM_SLOTS-1:0] ev_hit;
  logic [NUM_SLOTS-1:0] inc_slot;
  logic [NUM_SLOTS-1:0] clr_slot;
  logic [NUM_SLOTS-1:0] wrap_slot;
  logic [NUM_SLOTS-1:0] flag_clr;
  logic [LONG_W-1:0]    cnt_val [NUM_SLOTS];
  logic [SHORT_W-1:0]   cyc_cnt;
  logic [SHORT_W-1:0]   cnt0_val;

  assign pready   = 1'b1;
  assign wr_en    = psel & penable & pwrite;
  assign evsel_wr = wr_en && (paddr[11:4] == EVSEL_PAGE) && (paddr[1:0] == 2'b00);

  always_comb begin
    clr_slot = '0;
    flag_clr = '0;
    if (wr_en && paddr == A_CTRL) begin
      clr_slot[NUM_EVCNT-1:0] = {NUM_EVCNT{pwdata[1]}};
      clr_slot[CYC_SLOT]      = pwdata[2];
    end
    if (wr_en && paddr == A_CRST)  clr_slot = mask_to_slots(pwdata);
    if (wr_en && paddr == A_FLAGS) flag_clr = mask_to_slots(pwdata);
  end

  assign ev_hit[CYC_SLOT] = 1'b1;
  assign inc_slot = {NUM_SLOTS{glb_en}} & cnt_en & ev_hit;

  for (genvar i = 0; i < NUM_EVCNT; i++) begin : g_sel
    perfmon_evsel #(.NUM_EVENTS(NUM_EVENTS)) u_sel (
      .ev_in (ev_in),
      .code  (ev_code[i]),
      .hit   (ev_hit[i])
    );
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cnt
    if (i == 2 || i == 3) begin : g_long
      perfmon_counter #(.W(LONG_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .clr(clr_slot[i]), .inc(inc_slot[i]),
        .value(cnt_val[i]), .wrap(wrap_slot[i])
      );
    end else begin : g_short
      logic [SHORT_W-1:0] v_short;
      perfmon_counter #(.W(SHORT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .clr(clr_slot[i]), .inc(inc_slot[i]),
        .value(v_short), .wrap(wrap_slot[i])
      );
      assign cnt_val[i] = LONG_W'(v_short);
    end
  end

  assign cyc_cnt  = cnt_val[CYC_SLOT][SHORT_W-1:0];
  assign cnt0_val = cnt_val[0][SHORT_W-1:0];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      glb_en  <= 1'b0;
      mode    <= 2'd0;
      cnt_en  <= '0;
      int_en  <= '0;
      flags   <= '0;
      for (int i = 0; i < NUM_EVCNT; i++) ev_code[i] <= 8'd0;
    end else begin
      // A wrap in the same cycle as a clear keeps the flag.
      flags <= (flags & ~flag_clr) | wrap_slot;
      if (wr_en) begin
        case (paddr)
          A_CTRL: begin
            glb_en <= pwdata[0];
            mode   <= pwdata[21:20];
          end
          A_CEN_SET: cnt_en <= cnt_en |  mask_to_slots(pwdata);
          A_CEN_CLR: cnt_en <= cnt_en & ~mask_to_slots(pwdata);
          A_IEN_SET: int_en <= int_en |  mask_to_slots(pwdata);
          A_IEN_CLR: int_en <= int_en & ~mask_to_slots(pwdata);
          default: ;
        endcase
      end
      if (evsel_wr) ev_code[paddr[3:2]] <= pwdata[7:0];
    end
  end

  assign irq = |(flags & int_en);

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (paddr)
      A_VERSION:            rd_word = version_word();
      A_CTRL:               begin rd_word[21:20] = mode; rd_word[0] = glb_en; end
      A_CEN_SET, A_CEN_CLR: rd_word = slots_to_mask(cnt_en);
      A_IEN_SET, A_IEN_CLR: rd_word = slots_to_mask(int_en);
      A_FLAGS:              rd_word = slots_to_mask(flags);
      A_CNT0:               rd_word = 32'(cnt_val[0][SHORT_W-1:0]);
      A_CNT1:               rd_word = 32'(cnt_val[1][SHORT_W-1:0]);
      A_CNT2_LO:            rd_word = 32'(cnt_val[2][SHORT_W-1:0]);
      A_CNT3_LO:            rd_word = 32'(cnt_val[3][SHORT_W-1:0]);
      A_CNT2_HI:            rd_word = 32'(cnt_val[2][LONG_W-1:SHORT_W]);
      A_CNT3_HI:            rd_word = 32'(cnt_val[3][LONG_W-1:SHORT_W]);
      A_CYC:                rd_word = 32'(cnt_val[CYC_SLOT][SHORT_W-1:0]);
      default: begin
        if (paddr[11:4] == EVSEL_PAGE && paddr[1:0] == 2'b00)
          rd_word = {24'd0, ev_code[paddr[3:2]]};
      end
    endcase
  end

  assign prdata = (psel && !pwrite) ? rd_word : 32'd0;

  logic unused_hi;
  assign unused_hi = (HI_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/perfmon_apb_checker.sv
module perfmon_apb_checker #(
  parameter int SHORT_W = 32
) (
  input logic               pclk,
  input logic               presetn,
  input logic               psel,
  input logic               pwrite,
  input logic [11:0]        paddr,
  input logic [31:0]        prdata,
  input logic               glb_en,
  input logic [4:0]         clr_slot,
  input logic [4:0]         wrap_slot,
  input logic [4:0]         flags,
  input logic [4:0]         int_en,
  input logic               irq,
  input logic [SHORT_W-1:0] cyc_cnt,
  input logic [SHORT_W-1:0] cnt0_val
);
  assert_ctrl_pulse_R2: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == 12'h004) |-> (prdata[2:1] == 2'b00));

  assert_hold_when_off_R4: assert property (@(posedge pclk) disable iff (!presetn)
    (!glb_en && !clr_slot[4]) |=> $stable(cyc_cnt));

  assert_single_step_R4: assert property (@(posedge pclk) disable iff (!presetn)
    !clr_slot[0] |=> (cnt0_val == $past(cnt0_val) || cnt0_val == $past(cnt0_val) + SHORT_W'(1)));

  assert_flag_on_wrap_R6: assert property (@(posedge pclk) disable iff (!presetn)
    wrap_slot[4] |=> flags[4]);

  assert_irq_quiet_R7: assert property (@(posedge pclk) disable iff (!presetn)
    (int_en == 5'd0) |-> !irq);

  assert_reset_wins_R8: assert property (@(posedge pclk) disable iff (!presetn)
    clr_slot[0] |=> (cnt0_val == '0));
endmodule

bind perfmon_apb perfmon_apb_checker #(.SHORT_W(SHORT_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .pwrite(pwrite), .paddr(paddr),
  .prdata(prdata), .glb_en(glb_en), .clr_slot(clr_slot), .wrap_slot(wrap_slot),
  .flags(flags), .int_en(int_en), .irq(irq), .cyc_cnt(cyc_cnt), .cnt0_val(cnt0_val)
);

// File: tb/perfmon_apb_bench.sv
`timescale 1ns/1ps
module perfmon_apb_bench;
  localparam int SW = 8;
  localparam int LW = 12;
  localparam int NE = 16;

  logic          pclk = 1'b0, presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0]   paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [NE-1:0] ev_in = '0;
  wire  [31:0]   prdata;
  wire           pready, irq;

  int checks = 0, errors = 0, ev_mode = 0;
  bit done = 0;

  perfmon_apb #(.SHORT_W(SW), .LONG_W(LW), .NUM_EVENTS(NE)) u_perfmon_apb (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .ev_in(ev_in), .irq(irq)
  );

  always #2.5 pclk = ~pclk;

  // Behavioural reference model
  bit     m_glb;
  int     m_mode;
  bit     m_cen[5], m_ien[5], m_flg[5];
  int     m_code[4];
  longint m_cnt[5];

  function automatic longint m_max(input int i);
    return (i == 2 || i == 3) ? ((longint'(1) << LW) - 1) : ((longint'(1) << SW) - 1);
  endfunction
  function automatic int bitpos(input int i);
    return (i == 4) ? 31 : i;
  endfunction
  function automatic logic [31:0] m_mask(input bit a[5]);
    logic [31:0] r = 0;
    for (int i = 0; i < 5; i++) if (a[i]) r[bitpos(i)] = 1'b1;
    return r;
  endfunction
  function automatic logic [31:0] m_read(input logic [11:0] a);
    longint lo = (longint'(1) << SW) - 1;
    case (a)
      12'h000: return 32'h0004_5000;
      12'h004: return (32'(m_mode) << 20) | 32'(m_glb);
      12'h008, 12'h00C: return m_mask(m_cen);
      12'h010, 12'h014: return m_mask(m_ien);
      12'h018: return m_mask(m_flg);
      12'h034: return 32'(m_cnt[0] & lo);
      12'h038: return 32'(m_cnt[1] & lo);
      12'h03C: return 32'(m_cnt[2] & lo);
      12'h040: return 32'(m_cnt[3] & lo);
      12'h044: return 32'(m_cnt[3] >> SW);
      12'h048: return 32'(m_cnt[4] & lo);
      12'h054: return 32'(m_cnt[2] >> SW);
      12'h200: return 32'(m_code[0]);
      12'h204: return 32'(m_code[1]);
      12'h208: return 32'(m_code[2]);
      12'h20C: return 32'(m_code[3]);
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge pclk) begin
    bit wr, hit, inc, clr, wrp;
    logic [31:0] d;
    if (!presetn) begin
      m_glb = 0; m_mode = 0;
      for (int i = 0; i < 5; i++) begin m_cen[i] = 0; m_ien[i] = 0; m_flg[i] = 0; m_cnt[i] = 0; end
      for (int i = 0; i < 4; i++) m_code[i] = 0;
    end else begin
      wr = psel && penable && pwrite;
      d  = pwdata;
      for (int i = 0; i < 5; i++) begin
        if (i == 4) hit = 1;
        else hit = (m_code[i] < NE) ? ev_in[m_code[i]] : 1'b0;
        inc = m_glb && m_cen[i] && hit;
        clr = wr && ((paddr == 12'h02C && d[bitpos(i)]) ||
                     (paddr == 12'h004 && ((i == 4) ? d[2] : d[1])));
        wrp = 0;
        if (clr) m_cnt[i] = 0;
        else if (inc) begin
          if (m_cnt[i] == m_max(i)) begin m_cnt[i] = 0; wrp = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
        if (wr && paddr == 12'h018 && d[bitpos(i)]) m_flg[i] = 0;
        if (wrp) m_flg[i] = 1;
      end
      if (wr) begin
        for (int i = 0; i < 5; i++) begin
          if (paddr == 12'h008 && d[bitpos(i)]) m_cen[i] = 1;
          if (paddr == 12'h00C && d[bitpos(i)]) m_cen[i] = 0;
          if (paddr == 12'h010 && d[bitpos(i)]) m_ien[i] = 1;
          if (paddr == 12'h014 && d[bitpos(i)]) m_ien[i] = 0;
        end
        if (paddr == 12'h004) begin m_glb = d[0]; m_mode = int'(d[21:20]); end
        for (int i = 0; i < 4; i++) if (paddr == 12'h200 + 12'(4 * i)) m_code[i] = int'(d[7:0]);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Interrupt compared against the model on every clock (R7)
  always @(negedge pclk) begin
    bit e;
    if (presetn && !done) begin
      #1;
      e = 0;
      for (int i = 0; i < 5; i++) e = e | (m_flg[i] & m_ien[i]);
      check(irq == e, "R7 irq", 32'(irq), 32'(e));
    end
  end

  initial forever begin
    @(negedge pclk);
    case (ev_mode)
      0: ev_in = '0;
      1: ev_in = '1;
      default: ev_in = NE'($urandom);
    endcase
  end

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [11:0] a, input string tag);
    logic [31:0] e;
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; #1;
    e = m_read(a);
    check(prdata === e, tag, prdata, e);
    check(pready === 1'b1, "R1 pready", 32'(pready), 32'h1);
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic read_counters(input string tag);
    apb_read(12'h034, tag); apb_read(12'h038, tag); apb_read(12'h03C, tag);
    apb_read(12'h040, tag); apb_read(12'h048, tag);
  endtask

  initial begin
    repeat (4) @(negedge pclk);
    presetn = 1;
    // Reset state
    apb_read(12'h000, "R1 version");
    apb_read(12'h100, "R1 undefined");
    apb_read(12'h004, "R2 ctrl reset");
    apb_read(12'h018, "R6 flags reset");
    read_counters("R5 counters reset");
    // Event codes: counter 3 gets a code past the inputs
    apb_write(12'h200, 32'h0); apb_write(12'h204, 32'h1);
    apb_write(12'h208, 32'h2); apb_write(12'h20C, 32'h14);
    apb_read(12'h20C, "R4 code readback");
    // Enable masks
    apb_write(12'h008, 32'h8000_000F);
    apb_read(12'h008, "R3 cen set"); apb_read(12'h00C, "R3 cen clr alias");
    apb_write(12'h00C, 32'h0000_0002);
    apb_read(12'h00C, "R3 cen after clear");
    apb_write(12'h008, 32'h0000_0002);
    // Global disable: nothing moves
    ev_mode = 1; repeat (20) @(negedge pclk);
    read_counters("R4 global off");
    // Steady events
    apb_write(12'h004, 32'h1);
    repeat (20) @(negedge pclk);
    read_counters("R4 all events");
    apb_read(12'h044, "R5 cnt3 high");
    // Random events
    ev_mode = 2; repeat (300) @(negedge pclk);
    read_counters("R4 random events");
    // Control reset pulses and mode field
    apb_write(12'h004, 32'h0030_0007);
    apb_read(12'h004, "R2 pulses read zero, mode kept");
    read_counters("R2 after control reset");
    // Per-counter reset while events keep arriving
    ev_mode = 1;
    apb_write(12'h02C, 32'h0000_0001);
    apb_read(12'h034, "R8 counter0 reset");
    apb_read(12'h02C, "R8 reset reg reads zero");
    apb_write(12'h02C, 32'h8000_0000);
    apb_read(12'h048, "R8 cycle counter reset");
    // Wraps: short counters every 256 cycles, long every 4096
    apb_write(12'h010, 32'h8000_0000);
    repeat (300) @(negedge pclk);
    apb_read(12'h018, "R6 short wrap flags");
    apb_write(12'h018, 32'h8000_0000);
    apb_read(12'h018, "R6 clear cycle flag");
    repeat (4200) @(negedge pclk);
    apb_read(12'h018, "R6 long wrap flag");
    apb_read(12'h054, "R5 cnt2 high");
    apb_read(12'h03C, "R5 cnt2 low");
    apb_write(12'h010, 32'h0000_0004);
    apb_read(12'h010, "R7 int enable mask");
    apb_write(12'h018, 32'h8000_000F);
    apb_read(12'h018, "R6 clear all");
    apb_write(12'h014, 32'h8000_0004);
    ev_mode = 2; repeat (600) @(negedge pclk);
    apb_read(12'h018, "R6 random flags");
    read_counters("R4 final random");
    ev_mode = 0;
    repeat (4) @(negedge pclk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule